// File: doc/BRIEF.md
# Parallel Byte Transmitter with Four-Phase Handshake

This block moves bytes one at a time from an on-chip producer to an external receiver over a one-way 8-bit parallel bus. The producer hands over a byte with a valid/ready handshake. The block stores the byte, drives it onto the bus, waits a set number of clocks, and then pulls the active-low strobe low. The strobe stays low until the receiver answers with acknowledge and a minimum pulse width has passed, whichever comes later. The strobe is then released.

The receiver can also raise a busy line to hold off the sender. A new byte is taken only after the receiver has dropped both acknowledge and busy. Both receiver lines are asynchronous to the block's clock, so each one passes through a two-flop synchroniser before the sequencer uses it. The setup time and the minimum strobe width are parameters.

Top module: `pbyte_tx`

## Requirements
- R1: While reset is high and on the first cycle after it, `pp_strobe_n` is 1, `pp_data` is 0 and the sequencer is idle, so `in_ready` is 1 when both receiver lines are low.
- R2: `in_ready` is 1 only while no transfer is in progress. Whenever `in_ready` is 1, `pp_strobe_n` is 1.
- R3: The byte on `in_data` in the cycle where `in_valid` and `in_ready` are both 1 appears on `pp_data` on the next cycle. It stays unchanged until the next accepted byte, whatever `in_data` does in between.
- R4: `pp_strobe_n` falls exactly `SETUP_CLKS` clock cycles after the accepting clock edge.
- R5: `pp_strobe_n` stays low for at least `STROBE_MIN` cycles. When acknowledge rises on the k-th low cycle, the low time is exactly max(`STROBE_MIN`, k+2) cycles.
- R6: `pp_strobe_n` is released only after the synchronised acknowledge has been seen high. Without acknowledge it stays low for as long as needed.
- R7: After a transfer, `in_ready` returns to 1 on the third cycle after the later of the two falling edges of acknowledge and busy, and not earlier.
- R8: If busy rises while idle, `in_ready` drops two cycles later. While busy is held high, `in_valid` starts no transfer and `pp_strobe_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte offered by the producer |
| in_valid | input | 1 | Producer has a byte |
| in_ready | output | 1 | Block will take a byte at this edge |
| pp_data | output | 8 | Parallel data bus to the receiver |
| pp_strobe_n | output | 1 | Active-low data strobe |
| pp_ack | input | 1 | Receiver acknowledge (asynchronous) |
| pp_busy | input | 1 | Receiver busy (asynchronous) |

## Verification
The assertions assume a well-behaved receiver. It raises acknowledge only while the strobe is low and holds it until the strobe has been released. It keeps acknowledge and busy low during reset and during the two cycles after it. The bench's receiver model follows these rules. It raises acknowledge only after it has seen the strobe low, keeps acknowledge high for at least one cycle after the strobe rises, and raises busy only once the strobe is high or the block is idle. The delays it uses are chosen so that each release, and each low time of the strobe, has a single expected cycle count.

// File: rtl/pbyte_pkg.sv
package pbyte_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT_ACK,
        ST_WAIT_REL
    } seq_state_t;

    // receiver-side lines after synchronisation
    typedef struct packed {
        logic busy;
        logic ack;
    } rx_lines_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic strobe_on(input seq_state_t s);
        return (s == ST_STROBE) || (s == ST_WAIT_ACK);
    endfunction

    function automatic logic lines_clear(input rx_lines_t r);
        return !r.ack && !r.busy;
    endfunction

endpackage

// File: rtl/pbyte_sync.sv
module pbyte_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pbyte_timer.sv
module pbyte_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pbyte_fsm.sv
module pbyte_fsm
    import pbyte_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 3,
    parameter int SETUP_CLKS = 3,
    parameter int STROBE_MIN = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  rx_lines_t         rx,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic [DATA_W-1:0] bus_data,
    output logic              strobe_n
);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CLKS - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_MIN - 1);

    seq_state_t state, nxt;
    logic       ack_seen;
    logic       take;

    assign in_ready = (state == ST_IDLE) && lines_clear(rx);
    assign take     = in_valid && in_ready;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    nxt      = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = STROBE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_zero) begin
                    nxt = (ack_seen || rx.ack) ? ST_WAIT_REL : ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (rx.ack) begin
                    nxt = ST_WAIT_REL;
                end
            end
            ST_WAIT_REL: begin
                if (lines_clear(rx)) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ack_seen <= 1'b0;
            bus_data <= '0;
        end else begin
            state <= nxt;
            if (take) begin
                bus_data <= in_data;
            end
            if (state != ST_STROBE) begin
                ack_seen <= 1'b0;
            end else if (rx.ack) begin
                ack_seen <= 1'b1;
            end
        end
    end

    assign strobe_n = !strobe_on(state);
endmodule

// File: rtl/pbyte_tx.sv
module pbyte_tx
    import pbyte_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SETUP_CLKS  = 3,
    parameter int STROBE_MIN  = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] pp_data,
    output logic              pp_strobe_n,
    input  logic              pp_ack,
    input  logic              pp_busy
);
    localparam int CNT_W = $clog2(max_int(SETUP_CLKS, STROBE_MIN) + 1);

    rx_lines_t        rx;
    logic [1:0]       rx_raw;
    logic [1:0]       rx_sync;
    logic             ack_s;
    logic             busy_s;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;

    assign rx_raw = {pp_busy, pp_ack};
    assign rx     = rx_lines_t'(rx_sync);
    assign ack_s  = rx.ack;
    assign busy_s = rx.busy;

    pbyte_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (rx_raw),
        .sync_out (rx_sync)
    );

    pbyte_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pbyte_fsm #(
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .SETUP_CLKS (SETUP_CLKS),
        .STROBE_MIN (STROBE_MIN)
    ) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .rx       (rx),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .bus_data (pp_data),
        .strobe_n (pp_strobe_n)
    );
endmodule

// File: rtl/pbyte_tx_checker.sv
module pbyte_tx_checker #(
    parameter int DATA_W     = 8,
    parameter int SETUP_CLKS = 3,
    parameter int STROBE_MIN = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] pp_data,
    input logic              pp_strobe_n,
    input logic              pp_ack,
    input logic              pp_busy,
    input logic              ack_s
);
    logic [15:0] since_take;
    logic [15:0] low_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_take <= 16'hFFFF;
            low_len    <= '0;
        end else begin
            if (in_valid && in_ready) begin
                since_take <= '0;
            end else if (since_take != 16'hFFFF) begin
                since_take <= since_take + 1'b1;
            end
            low_len <= pp_strobe_n ? '0 : low_len + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pp_strobe_n && pp_data == '0));

    assert_ready_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> pp_strobe_n);

    assert_capture_byte_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (pp_data == $past(in_data)));

    assert_hold_byte_R3: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(pp_data));

    assert_setup_len_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pp_strobe_n) |-> (since_take == 16'(SETUP_CLKS)));

    assert_min_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(pp_strobe_n) |-> (low_len >= 16'(STROBE_MIN)));

    assert_release_after_ack_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(pp_strobe_n) |-> $past(ack_s));

    assert_ready_lines_clear_R7: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!$past(pp_ack, 2) && !$past(pp_busy, 2)));
endmodule

bind pbyte_tx pbyte_tx_checker #(
    .DATA_W     (DATA_W),
    .SETUP_CLKS (SETUP_CLKS),
    .STROBE_MIN (STROBE_MIN)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_data     (in_data),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .pp_data     (pp_data),
    .pp_strobe_n (pp_strobe_n),
    .pp_ack      (pp_ack),
    .pp_busy     (pp_busy),
    .ack_s       (ack_s)
);

// File: tb/test_pbyte_tx.sv
module test_pbyte_tx;
    localparam int SETUP = 3;
    localparam int SMIN  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] pp_data;
    logic       pp_strobe_n;
    logic       pp_ack = 1'b0;
    logic       pp_busy = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pbyte_tx #(
        .DATA_W      (8),
        .SETUP_CLKS  (SETUP),
        .STROBE_MIN  (SMIN),
        .SYNC_STAGES (2)
    ) i_pbyte_tx (
        .clk         (clk),
        .rst         (rst),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .pp_data     (pp_data),
        .pp_strobe_n (pp_strobe_n),
        .pp_ack      (pp_ack),
        .pp_busy     (pp_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 strobe in reset", 32'(pp_strobe_n), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobe after reset", 32'(pp_strobe_n), 32'd1);
        chk("R1 data after reset", 32'(pp_data), 32'd0);
        chk("R1 ready after reset", 32'(in_ready), 32'd1);
    endtask

    // one full transfer; ack rises on the ack_at-th low cycle,
    // ack falls ack_hold cycles and busy busy_hold cycles after strobe release
    task automatic t_xfer(input logic [7:0] b, input int ack_at,
                          input int ack_hold, input int busy_hold);
        int hi = 0;
        int lo = 0;
        int last;
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        chk("R2 strobe high while ready", 32'(pp_strobe_n), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~b;
        chk("R2 ready low during transfer", 32'(in_ready), 32'd0);
        while (pp_strobe_n && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        chk("R4 setup cycles before strobe", 32'(hi), 32'(SETUP));
        chk("R3 byte on bus at strobe", 32'(pp_data), 32'(b));
        while (!pp_strobe_n && lo < 1000) begin
            lo++;
            if (lo == ack_at) pp_ack = 1'b1;
            @(negedge clk);
        end
        chk("R5 strobe low width", 32'(lo), 32'((SMIN > ack_at + 2) ? SMIN : ack_at + 2));
        chk("R6 ack high at release", 32'(pp_ack), 32'd1);
        if (busy_hold > 0) pp_busy = 1'b1;
        last = (ack_hold > busy_hold) ? ack_hold : busy_hold;
        for (int i = 1; i <= last; i++) begin
            chk("R7 ready low while receiver lines held", 32'(in_ready), 32'd0);
            chk("R3 byte held after strobe", 32'(pp_data), 32'(b));
            if (i == ack_hold)  pp_ack  = 1'b0;
            if (i == busy_hold) pp_busy = 1'b0;
            @(negedge clk);
        end
        chk("R7 ready low 1 after release", 32'(in_ready), 32'd0);
        @(negedge clk);
        chk("R7 ready low 2 after release", 32'(in_ready), 32'd0);
        @(negedge clk);
        chk("R7 ready back 3 after release", 32'(in_ready), 32'd1);
        chk("R3 byte still held in idle", 32'(pp_data), 32'(b));
    endtask

    // R8: busy in idle blocks new transfers
    task automatic t_busy_idle();
        pp_busy = 1'b1;
        @(negedge clk);
        chk("R8 ready 1 cycle after busy", 32'(in_ready), 32'd1);
        @(negedge clk);
        chk("R8 ready low 2 cycles after busy", 32'(in_ready), 32'd0);
        in_data  = 8'h77;
        in_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R8 no strobe while busy", 32'(pp_strobe_n), 32'd1);
        end
        chk("R8 data unchanged while busy", 32'(pp_data) == 32'h77 ? 32'd1 : 32'd0, 32'd0);
        in_valid = 1'b0;
        pp_busy  = 1'b0;
        @(negedge clk);
        chk("R8 ready low 1 after busy drop", 32'(in_ready), 32'd0);
        @(negedge clk);
        chk("R8 ready back 2 after busy drop", 32'(in_ready), 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_xfer(8'hA5, 1, 1, 0);
        t_xfer(8'h3C, 7, 2, 0);
        t_xfer(8'h5A, 3, 1, 4);
        t_busy_idle();
        t_xfer(8'hFF, 2, 3, 1);
        t_xfer(8'h00, 10, 1, 2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule